// File: doc/BRIEF.md
# Secure boot address selector

This block picks the initial vector table addresses for a processor core as it leaves reset. From a boot pin, a set of option fields and a read-protection level, it derives one secure vector and one nonsecure vector. The inputs it uses are the boot pin, a pin-or-software source select, an inverted software boot bit, two nonsecure boot addresses, one secure boot address, a security-extension enable and a boot lock. It also takes the command word from a root security service. When the security extension is on, the selection also depends on the boot lock and on that command word. A programmed address that lies outside the window the protection level allows is replaced by a fixed fallback address.

The effective boot bit is captured once, just after reset is released, and captured again each time the chip leaves standby. A start-up delay counter then runs. A one-cycle select strobe loads the vector registers, and only after that does the block release the core from reset. The vectors stay unchanged while the core runs.

Top module: `boot_vector_sel`

## Requirements
- R1: The effective boot bit equals `boot_pin` when `opt_pin_sel` is 1, and equals the inverse of `opt_nsw_boot` when `opt_pin_sel` is 0.
- R2: With `opt_sec_en` = 0, `vtor_ns` is `opt_ns_addr0` for boot bit 0 and `opt_ns_addr1` for boot bit 1, and `vtor_s` is 0.
- R3: With `opt_sec_en` = 1 and `opt_boot_lock` = 0, `vtor_s` is `opt_sec_addr` when the boot bit is 0 and `rss_cmd` is zero. Otherwise it is the root-service entry 0x0FF8_0000.
- R4: With `opt_sec_en` = 1, `vtor_ns` is `opt_ns_addr0` for boot bit 0 and `opt_ns_addr1` for boot bit 1. No range check is applied to it.
- R5: With `opt_sec_en` = 1 and `opt_boot_lock` = 1, `vtor_s` is `opt_sec_addr`, whatever the boot bit and `rss_cmd` are (subject to R6).
- R6: With `opt_sec_en` = 1 and `prot_lvl` other than 2'b00, a secure vector that is not 0x0FF8_0000 and lies outside 0x0C00_0000..0x0C1F_FFFF is replaced by 0x0FF8_0000.
- R7: With `opt_sec_en` = 0 and `prot_lvl` = 2'b11, a nonsecure vector outside 0x0800_0000..0x081F_FFFF is replaced by 0x0800_0000. The codes 2'b00, 2'b01 and 2'b10 apply no range check.
- R8: With `prot_lvl` = 2'b00, any programmed secure address is passed through unchanged.
- R9: The boot bit is captured in the first cycle after reset release. Later changes of `boot_pin` or `opt_nsw_boot` have no effect on the vectors until the next capture.
- R10: `sel_strobe` is high for exactly one cycle. `core_rst_rel` rises in the cycle after the strobe, STARTUP_CYC+2 cycles after the first cycle with `rst_n` high.
- R11: A `stby_exit` pulse while `core_rst_rel` is high drops `core_rst_rel` in the next cycle, recaptures the boot bit and repeats the delay, strobe and release. While `core_rst_rel` stays high, the vectors do not change.
- R12: While `rst_n` is low, `core_rst_rel`, `sel_strobe`, `vtor_s` and `vtor_ns` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stby_exit | input | 1 | One-cycle pulse on exit from standby |
| boot_pin | input | 1 | External boot pin level |
| opt_pin_sel | input | 1 | 1: boot bit from pin, 0: from software option |
| opt_nsw_boot | input | 1 | Inverted software boot bit |
| opt_ns_addr0 | input | ADDR_W | Nonsecure boot address for boot bit 0 |
| opt_ns_addr1 | input | ADDR_W | Nonsecure boot address for boot bit 1 |
| opt_sec_addr | input | ADDR_W | Secure boot address |
| opt_sec_en | input | 1 | Security extension enable |
| opt_boot_lock | input | 1 | Forces the secure boot address |
| prot_lvl | input | 2 | Read-protection level code |
| rss_cmd | input | CMD_W | Root-service command word |
| vtor_s | output | ADDR_W | Secure initial vector address |
| vtor_ns | output | ADDR_W | Nonsecure initial vector address |
| sel_strobe | output | 1 | One-cycle pulse when the vectors are loaded |
| core_rst_rel | output | 1 | High when the core may leave reset |

## Verification
The bench builds the block with STARTUP_CYC = 4, which keeps each boot sequence to a few cycles. That makes it practical to boot once for every combination of security enable, lock, boot bit source, boot bit value, zero or nonzero command and all four protection codes, each against four address sets. The address sets cover inside, both window edges, just outside and the exact root-service entry. The widths stay at their defaults (32-bit addresses, 8-bit command), so the fixed window limits are exercised exactly as built.

// File: rtl/boot_sel_pkg.sv
// Shared types for the boot vector selector.
// Assumes: 2-bit protection code, 00 = lowest level, 11 = highest.
package boot_sel_pkg;

    typedef enum logic [1:0] {
        SQ_HOLD = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_PICK = 2'd2,
        SQ_RUN  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        PL_OPEN   = 2'b00,
        PL_HALF   = 2'b01,
        PL_ONE    = 2'b10,
        PL_LOCKED = 2'b11
    } prot_lvl_t;

endpackage

// File: rtl/boot_seq_ctrl.sv
// Start-up sequencer: after reset release (or standby exit while running)
// it requests a boot-bit capture, waits STARTUP_CYC cycles, strobes the
// vector load for one cycle, then releases the core.
// Assumes: stby_exit is a single-cycle pulse; it is ignored unless running.
module boot_seq_ctrl
    import boot_sel_pkg::*;
#(
    parameter int STARTUP_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_exit,
    output logic capture_o,
    output logic strobe_o,
    output logic release_o
);
    localparam int CNT_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STARTUP_CYC - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Advance the sequence and the delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_HOLD;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_HOLD: begin
                    state <= SQ_WAIT;
                    cnt   <= '0;
                end
                SQ_WAIT: begin
                    if (cnt == LAST) state <= SQ_PICK;
                    else             cnt   <= cnt + 1'b1;
                end
                SQ_PICK: state <= SQ_RUN;
                default: begin
                    if (stby_exit) begin
                        state <= SQ_WAIT;
                        cnt   <= '0;
                    end
                end
            endcase
        end
    end

    // Decode the sequence state into the control outputs.
    always_comb begin
        capture_o = (state == SQ_HOLD) || ((state == SQ_RUN) && stby_exit);
        strobe_o  = (state == SQ_PICK);
        release_o = (state == SQ_RUN);
    end

    a_r10_strobe_then_release: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> (release_o && !strobe_o));
    a_r11_standby_drops_release: assert property (@(posedge clk) disable iff (!rst_n)
        (release_o && stby_exit) |=> !release_o);
endmodule

// File: rtl/boot_bit_latch.sv
// Resolves the effective boot bit from its pin or software source and
// holds it between capture requests.
// Assumes: capture is high only in the cycles the sequencer asks for it.
module boot_bit_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic pin_sel,
    input  logic pin,
    input  logic nsw_boot,
    output logic bit_q
);
    logic bit_d;

    // Choose the boot bit source.
    always_comb bit_d = pin_sel ? pin : ~nsw_boot;

    // Hold the boot bit until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       bit_q <= 1'b0;
        else if (capture) bit_q <= bit_d;
    end

    a_r9_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(bit_q));
endmodule

// File: rtl/boot_range_clamp.sv
// Window check on a boot address: when enabled, an address outside
// [LO, HI] (and, if KEEP_FALLBACK, not equal to FALLBACK) is replaced.
// Assumes: LO <= HI; purely combinational.
module boot_range_clamp #(
    parameter int              ADDR_W        = 32,
    parameter logic [ADDR_W-1:0] LO          = '0,
    parameter logic [ADDR_W-1:0] HI          = '1,
    parameter logic [ADDR_W-1:0] FALLBACK    = '0,
    parameter bit              KEEP_FALLBACK = 1'b0
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic in_win;
    logic ok;

    // Test the address against the window.
    always_comb in_win = (addr_i >= LO) && (addr_i <= HI);

    generate
        if (KEEP_FALLBACK) begin : g_keep
            // Accept the fallback address itself as legal.
            always_comb ok = in_win || (addr_i == FALLBACK);
        end else begin : g_plain
            // Only the window is legal.
            always_comb ok = in_win;
        end
    endgenerate

    // Replace an illegal address when checking is on.
    always_comb addr_o = (enable && !ok) ? FALLBACK : addr_i;
endmodule

// File: rtl/boot_vector_sel.sv
// Top: boot vector selector. Combines the latched boot bit, security mode,
// boot lock, root-service command and protection level into secure and
// nonsecure vector addresses, loaded once per boot by the sequencer.
// Assumes: option inputs are stable from reset release to the strobe.
module boot_vector_sel
    import boot_sel_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                CMD_W       = 8,
    parameter int                STARTUP_CYC = 16,
    parameter logic [ADDR_W-1:0] RSS_ENTRY   = 32'h0FF8_0000,
    parameter logic [ADDR_W-1:0] SEC_LO      = 32'h0C00_0000,
    parameter logic [ADDR_W-1:0] SEC_HI      = 32'h0C1F_FFFF,
    parameter logic [ADDR_W-1:0] NS_LO       = 32'h0800_0000,
    parameter logic [ADDR_W-1:0] NS_HI       = 32'h081F_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby_exit,
    input  logic              boot_pin,
    input  logic              opt_pin_sel,
    input  logic              opt_nsw_boot,
    input  logic [ADDR_W-1:0] opt_ns_addr0,
    input  logic [ADDR_W-1:0] opt_ns_addr1,
    input  logic [ADDR_W-1:0] opt_sec_addr,
    input  logic              opt_sec_en,
    input  logic              opt_boot_lock,
    input  logic [1:0]        prot_lvl,
    input  logic [CMD_W-1:0]  rss_cmd,
    output logic [ADDR_W-1:0] vtor_s,
    output logic [ADDR_W-1:0] vtor_ns,
    output logic              sel_strobe,
    output logic              core_rst_rel
);
    logic              capture;
    logic              boot_bit;
    logic [ADDR_W-1:0] sec_raw, ns_raw, sec_chk, ns_chk;
    logic              sec_clamp_en, ns_clamp_en;
    prot_lvl_t         lvl;

    boot_seq_ctrl #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stby_exit (stby_exit),
        .capture_o (capture),
        .strobe_o  (sel_strobe),
        .release_o (core_rst_rel)
    );

    boot_bit_latch u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .pin_sel  (opt_pin_sel),
        .pin      (boot_pin),
        .nsw_boot (opt_nsw_boot),
        .bit_q    (boot_bit)
    );

    // Raw choice of both vectors before range checks.
    always_comb begin
        lvl    = prot_lvl_t'(prot_lvl);
        ns_raw = boot_bit ? opt_ns_addr1 : opt_ns_addr0;
        if (opt_boot_lock || (!boot_bit && (rss_cmd == '0)))
            sec_raw = opt_sec_addr;
        else
            sec_raw = RSS_ENTRY;
        sec_clamp_en = (lvl != PL_OPEN);
        ns_clamp_en  = !opt_sec_en && (lvl == PL_LOCKED);
    end

    boot_range_clamp #(
        .ADDR_W(ADDR_W), .LO(SEC_LO), .HI(SEC_HI),
        .FALLBACK(RSS_ENTRY), .KEEP_FALLBACK(1'b1)
    ) u_sec_clamp (
        .enable (sec_clamp_en),
        .addr_i (sec_raw),
        .addr_o (sec_chk)
    );

    boot_range_clamp #(
        .ADDR_W(ADDR_W), .LO(NS_LO), .HI(NS_HI),
        .FALLBACK(NS_LO), .KEEP_FALLBACK(1'b0)
    ) u_ns_clamp (
        .enable (ns_clamp_en),
        .addr_i (ns_raw),
        .addr_o (ns_chk)
    );

    // Load the vectors on the select strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vtor_s  <= '0;
            vtor_ns <= '0;
        end else if (sel_strobe) begin
            vtor_s  <= opt_sec_en ? sec_chk : '0;
            vtor_ns <= ns_chk;
        end
    end

    a_r11_vectors_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_rel && $past(core_rst_rel)) |-> ($stable(vtor_s) && $stable(vtor_ns)));
    a_r10_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_rel) |-> $past(sel_strobe));
    a_r6_secure_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_strobe) && $past(opt_sec_en) && ($past(prot_lvl) != 2'b00))
        |-> ((vtor_s == RSS_ENTRY) || ((vtor_s >= SEC_LO) && (vtor_s <= SEC_HI))));
    a_r7_nonsecure_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_strobe) && !$past(opt_sec_en) && ($past(prot_lvl) == 2'b11))
        |-> ((vtor_ns >= NS_LO) && (vtor_ns <= NS_HI)));
    a_r5_lock_keeps_secure: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_strobe) && $past(opt_sec_en) && $past(opt_boot_lock) && ($past(prot_lvl) == 2'b00))
        |-> (vtor_s == $past(opt_sec_addr)));
    a_r2_secure_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_strobe) && !$past(opt_sec_en)) |-> (vtor_s == '0));
endmodule

// File: tb/sim_boot_vector_sel.sv
module sim_boot_vector_sel;
    localparam int STARTUP = 4;
    localparam logic [31:0] RSS  = 32'h0FF8_0000;
    localparam logic [31:0] SLO  = 32'h0C00_0000;
    localparam logic [31:0] SHI  = 32'h0C1F_FFFF;
    localparam logic [31:0] NLO  = 32'h0800_0000;
    localparam logic [31:0] NHI  = 32'h081F_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby_exit = 1'b0, boot_pin = 1'b0, opt_pin_sel = 1'b0, opt_nsw_boot = 1'b1;
    logic [31:0] opt_ns_addr0 = '0, opt_ns_addr1 = '0, opt_sec_addr = '0;
    logic opt_sec_en = 1'b0, opt_boot_lock = 1'b0;
    logic [1:0] prot_lvl = 2'b00;
    logic [7:0] rss_cmd = '0;
    logic [31:0] vtor_s, vtor_ns;
    logic sel_strobe, core_rst_rel;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] s;
        logic [31:0] ns;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    boot_vector_sel #(.STARTUP_CYC(STARTUP)) u0 (
        .clk(clk), .rst_n(rst_n), .stby_exit(stby_exit), .boot_pin(boot_pin),
        .opt_pin_sel(opt_pin_sel), .opt_nsw_boot(opt_nsw_boot),
        .opt_ns_addr0(opt_ns_addr0), .opt_ns_addr1(opt_ns_addr1),
        .opt_sec_addr(opt_sec_addr), .opt_sec_en(opt_sec_en),
        .opt_boot_lock(opt_boot_lock), .prot_lvl(prot_lvl), .rss_cmd(rss_cmd),
        .vtor_s(vtor_s), .vtor_ns(vtor_ns), .sel_strobe(sel_strobe),
        .core_rst_rel(core_rst_rel)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected vectors from the requirements, for a given boot bit.
    function automatic exp_t model(input bit b);
        exp_t e;
        e.ns = b ? opt_ns_addr1 : opt_ns_addr0;
        if (!opt_sec_en) begin
            e.s = '0;
            if (prot_lvl == 2'b11 && !(e.ns >= NLO && e.ns <= NHI)) e.ns = NLO;
            e.tag = (prot_lvl == 2'b11) ? "R1 R2 R7" : "R1 R2";
        end else begin
            e.s = (opt_boot_lock || (!b && rss_cmd == 0)) ? opt_sec_addr : RSS;
            if (prot_lvl != 2'b00 && !(e.s == RSS || (e.s >= SLO && e.s <= SHI))) e.s = RSS;
            e.tag = $sformatf("R1 R4 %s %s", opt_boot_lock ? "R5" : "R3",
                              (prot_lvl != 2'b00) ? "R6" : "R8");
        end
        return e;
    endfunction

    // Monitor: compare vectors with the scoreboard at each release.
    logic rel_d = 1'b0;
    always @(negedge clk) begin
        if (core_rst_rel && !rel_d) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected release", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(vtor_s == e.s, {e.tag, " vtor_s"}, vtor_s, e.s);
                check(vtor_ns == e.ns, {e.tag, " vtor_ns"}, vtor_ns, e.ns);
            end
        end
        rel_d <= core_rst_rel;
    end

    // Driver: reset, push the expectation, release, wait for the core release.
    task automatic boot_once(input bit b);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        sb.push_back(model(b));
        rst_n = 1'b1;
        while (!core_rst_rel) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_bit(input bit ps, input bit b);
        opt_pin_sel = ps;
        if (ps) begin boot_pin = b; opt_nsw_boot = b; end
        else    begin boot_pin = ~b; opt_nsw_boot = ~b; end
    endtask

    task automatic set_addrs(input int k);
        case (k)
            0: begin opt_ns_addr0 = 32'h0800_0100; opt_ns_addr1 = 32'h081F_FFFC; opt_sec_addr = SLO; end
            1: begin opt_ns_addr0 = NHI;           opt_ns_addr1 = NLO;           opt_sec_addr = SHI; end
            2: begin opt_ns_addr0 = 32'h0820_0000; opt_ns_addr1 = 32'h07FF_FFFF; opt_sec_addr = 32'h0C20_0000; end
            default: begin opt_ns_addr0 = 32'h2000_0000; opt_ns_addr1 = 32'h0BF9_0000; opt_sec_addr = RSS; end
        endcase
    endtask

    initial begin
        // R12: outputs during reset
        repeat (3) @(negedge clk);
        check(core_rst_rel == 0 && sel_strobe == 0, "R12 control in reset", {30'd0, core_rst_rel, sel_strobe}, 32'd0);
        check(vtor_s == 0 && vtor_ns == 0, "R12 vectors in reset", vtor_s | vtor_ns, 32'd0);

        // R10: strobe and release timing
        opt_sec_en = 1'b0; prot_lvl = 2'b00; set_addrs(0); set_bit(1'b1, 1'b0);
        sb.push_back(model(1'b0));
        @(negedge clk) rst_n = 1'b1;
        begin
            int n = 0;
            int strobe_at = -1;
            int strobes = 0;
            while (!core_rst_rel && n < 50) begin
                @(negedge clk);
                n++;
                if (sel_strobe) begin strobe_at = n; strobes++; end
            end
            check(n == STARTUP + 2, "R10 release cycle", n, STARTUP + 2);
            check(strobe_at == STARTUP + 1 && strobes == 1, "R10 single strobe before release", strobe_at, STARTUP + 1);
        end
        @(negedge clk);

        // R9: pin change after capture has no effect
        @(negedge clk) rst_n = 1'b0;
        opt_sec_en = 1'b1; opt_boot_lock = 1'b0; rss_cmd = 0; prot_lvl = 2'b00;
        set_addrs(0); set_bit(1'b1, 1'b0);
        @(negedge clk);
        sb.push_back(model(1'b0));
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        boot_pin = 1'b1;
        while (!core_rst_rel) @(negedge clk);
        @(negedge clk);
        check(vtor_s == SLO, "R9 late pin change ignored", vtor_s, SLO);

        // R11: standby exit recaptures the bit and reruns the sequence
        sb.push_back(model(1'b1));
        stby_exit = 1'b1;
        @(negedge clk) stby_exit = 1'b0;
        check(core_rst_rel == 0, "R11 release drops on standby exit", {31'd0, core_rst_rel}, 32'd0);
        while (!core_rst_rel) @(negedge clk);
        @(negedge clk);
        check(vtor_s == RSS && vtor_ns == opt_ns_addr1, "R11 resampled bit applied", vtor_s, RSS);
        repeat (5) @(negedge clk);
        check(vtor_s == RSS, "R11 vectors stable while running", vtor_s, RSS);

        // Full sweep across modes, levels and address sets
        for (int k = 0; k < 4; k++)
            for (int se = 0; se < 2; se++)
                for (int lk = 0; lk < 2; lk++)
                    for (int ps = 0; ps < 2; ps++)
                        for (int b = 0; b < 2; b++)
                            for (int cz = 0; cz < 2; cz++)
                                for (int lv = 0; lv < 4; lv++) begin
                                    set_addrs(k);
                                    opt_sec_en = se[0]; opt_boot_lock = lk[0];
                                    set_bit(ps[0], b[0]);
                                    rss_cmd = cz[0] ? 8'h5A : 8'h00;
                                    prot_lvl = lv[1:0];
                                    boot_once(b[0]);
                                end

        check(sb.size() == 0, "R10 every boot released", sb.size(), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule